// File: doc/BRIEF.md
# I2S Master Audio Transmitter

This block is a bus master for a stereo serial audio link using the standard I2S framing. It divides the system clock down to a serial bit clock and drives the word-select line. It shifts audio samples out MSB first on the data line. Each frame carries a left slot followed by a right slot. Word select is low for left and high for right. It changes one bit period before the first bit of the slot it announces.

Software feeds samples through one 16-bit write port. A sample is either a single half-word or two half-words, depending on the selected format. A transmit-empty flag tells software when the next write is accepted. A side flag tells it which channel that write belongs to. Samples narrower than the slot are zero-padded by the hardware. If a slot begins with no complete sample staged, the bit timing keeps running, zeros are sent and a sticky underrun flag is raised. When the enable is removed, the block completes the frame in progress before it stops.

Top module: `i2s_tx_master`

## Requirements
- R1: With `fmt`=0 each slot is 16 bits long and carries one written half-word. With `fmt`=1, 2 or 3 each slot is 32 bits long. Every slot is sent MSB first.
- R2: With `fmt`=1 one write fills a channel. The written half-word occupies slot bits 31:16, and slot bits 15:0 are sent as zero.
- R3: With `fmt`=2 or 3 a channel takes two writes. The first write becomes slot bits 31:16. With `fmt`=3 the second write becomes bits 15:0. With `fmt`=2 bits 15:8 of the second write become slot bits 15:8, and slot bits 7:0 are sent as zero.
- R4: Slots alternate left, right, left, and so on, starting with left after enable. `ch_right` is 0 when the next write belongs to left and 1 when it belongs to right. It only changes when a slot starts.
- R5: `ws` is 0 during left slots and 1 during right slots. It switches on the falling `sck` edge that carries the last bit of the previous slot. After enable, one lead-in bit period with `ws`=0 and `sd`=0 precedes the first left MSB.
- R6: `sd` and `ws` change only together with a falling edge of `sck`. While idle, `sck`, `ws` and `sd` are all 0.
- R7: The `sck` period is 2*max(`half_div`,1) system clock cycles. `half_div` and `fmt` are captured only while `busy` is 0, so changes made while busy have no effect.
- R8: A write is accepted only while `tx_empty` is 1. A write made while it is 0 is discarded. `tx_empty` rises only when a slot starts and takes the staged sample.
- R9: If a slot starts without a complete sample, that slot is sent as zeros and any half-written sample is dropped. The side still advances, and `underrun` is set. `underrun` stays set until a pulse on `underrun_clr`.
- R10: When `enable` falls, the block finishes the current frame through the end of its right slot. It then returns to idle with `busy`=0, `ws`=0 and `sck` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; dropping it ends after the current frame |
| half_div | input | DIV_W | System clocks per half bit-clock period (0 acts as 1) |
| fmt | input | 2 | Frame format: 0=16/16, 1=16/32, 2=24/32, 3=32/32 |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | HW | Half-word of sample data |
| underrun_clr | input | 1 | Clears the sticky underrun flag |
| tx_empty | output | 1 | Next write will be accepted |
| ch_right | output | 1 | Next write belongs to the right channel |
| underrun | output | 1 | Sticky underrun flag |
| busy | output | 1 | Frame transmission in progress |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Word select (0 left, 1 right) |
| sd | output | 1 | Serial data |

## Verification
The bench builds the block with its default parameters, HW=16 and DIV_W=8. It sweeps all four formats against `half_div` values 0, 2 and 3. These small dividers keep frames short, so every bit of every slot is captured on rising `sck` edges. Each captured slot is rebuilt and compared with a word computed from the written half-words, and bit-clock periods and `ws` transitions are checked alongside. A full-buffer write and a deliberate underrun with a half-written sample cover the discard and zero-fill paths.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  typedef enum logic [1:0] {
    FMT_16_16 = 2'd0,
    FMT_16_32 = 2'd1,
    FMT_24_32 = 2'd2,
    FMT_32_32 = 2'd3
  } fmt_e;
endpackage

// File: rtl/i2s_sck_gen.sv
module i2s_sck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             sck,
  output logic             fall
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sck_q, sck_d;
  logic [DIV_W-1:0] hd_eff;
  logic             last;

  assign hd_eff = (half_div == '0) ? DIV_W'(1) : half_div;
  assign last   = (cnt_q == hd_eff - DIV_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    sck_d = sck_q;
    if (!run) begin
      cnt_d = '0;
      sck_d = 1'b0;
    end else if (last) begin
      cnt_d = '0;
      sck_d = ~sck_q;
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assign sck  = sck_q;
  assign fall = run && last && sck_q;
endmodule

// File: rtl/i2s_sample_stager.sv
module i2s_sample_stager
  import i2s_tx_pkg::*;
#(
  parameter int HW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  fmt_e            fmt,
  input  logic            wr_en,
  input  logic [HW-1:0]   wr_data,
  input  logic            load,
  input  logic            underrun_clr,
  output logic [2*HW-1:0] word,
  output logic            full,
  output logic            next_right,
  output logic            underrun
);
  localparam int SLOT_W = 2 * HW;
  localparam int PAD    = HW / 2;

  logic [SLOT_W-1:0] stage_q, stage_d;
  logic              full_q, full_d;
  logic              half_q, half_d;
  logic              right_q, right_d;
  logic              unr_q, unr_d;

  always_comb begin
    stage_d = stage_q;
    full_d  = full_q;
    half_d  = half_q;
    right_d = right_q;
    unr_d   = unr_q;
    if (underrun_clr) unr_d = 1'b0;
    if (load) begin
      right_d = ~right_q;
      if (full_q) begin
        full_d = 1'b0;
      end else begin
        unr_d  = 1'b1;
        half_d = 1'b0;
      end
    end else if (wr_en && !full_q) begin
      if (fmt == FMT_16_16 || fmt == FMT_16_32) begin
        stage_d = {wr_data, {HW{1'b0}}};
        full_d  = 1'b1;
      end else if (!half_q) begin
        stage_d[SLOT_W-1:HW] = wr_data;
        half_d               = 1'b1;
      end else begin
        if (fmt == FMT_24_32) stage_d[HW-1:0] = {wr_data[HW-1:PAD], {PAD{1'b0}}};
        else                  stage_d[HW-1:0] = wr_data;
        full_d = 1'b1;
        half_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      full_q  <= 1'b0;
      half_q  <= 1'b0;
      right_q <= 1'b0;
      unr_q   <= 1'b0;
    end else begin
      stage_q <= stage_d;
      full_q  <= full_d;
      half_q  <= half_d;
      right_q <= right_d;
      unr_q   <= unr_d;
    end
  end

  assign word       = full_q ? stage_q : '0;
  assign full       = full_q;
  assign next_right = right_q;
  assign underrun   = unr_q;
endmodule

// File: rtl/i2s_serializer.sv
module i2s_serializer
  import i2s_tx_pkg::*;
#(
  parameter int SLOT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  fmt_e              fmt,
  input  logic              fall,
  input  logic [SLOT_W-1:0] word,
  input  logic              next_right,
  output logic              busy,
  output logic              load,
  output logic              ws,
  output logic              sd
);
  localparam int HALF  = SLOT_W / 2;
  localparam int IDX_W = $clog2(SLOT_W);

  logic              run_q, run_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              ws_q, ws_d;
  logic              sd_q, sd_d;
  logic [SLOT_W-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]  slot_last;
  logic [IDX_W-1:0]  idx_inc;

  assign slot_last = (fmt == FMT_16_16) ? IDX_W'(HALF - 1) : IDX_W'(SLOT_W - 1);
  assign idx_inc   = idx_q + IDX_W'(1);

  always_comb begin
    run_d = run_q;
    idx_d = idx_q;
    ws_d  = ws_q;
    sd_d  = sd_q;
    sh_d  = sh_q;
    load  = 1'b0;
    if (!run_q) begin
      if (enable) begin
        run_d = 1'b1;
        idx_d = slot_last;
        ws_d  = 1'b0;
        sd_d  = 1'b0;
      end
    end else if (fall) begin
      if (idx_q == slot_last) begin
        if (!next_right && !enable) begin
          run_d = 1'b0;
          sd_d  = 1'b0;
        end else begin
          load  = 1'b1;
          idx_d = '0;
          sd_d  = word[SLOT_W-1];
          sh_d  = {word[SLOT_W-2:0], 1'b0};
        end
      end else begin
        idx_d = idx_inc;
        sd_d  = sh_q[SLOT_W-1];
        sh_d  = {sh_q[SLOT_W-2:0], 1'b0};
        if (idx_inc == slot_last) ws_d = ~ws_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      idx_q <= '0;
      ws_q  <= 1'b0;
      sd_q  <= 1'b0;
      sh_q  <= '0;
    end else begin
      run_q <= run_d;
      idx_q <= idx_d;
      ws_q  <= ws_d;
      sd_q  <= sd_d;
      sh_q  <= sh_d;
    end
  end

  assign busy = run_q;
  assign ws   = ws_q;
  assign sd   = sd_q;
endmodule

// File: rtl/i2s_tx_master.sv
module i2s_tx_master
  import i2s_tx_pkg::*;
#(
  parameter int HW    = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] half_div,
  input  logic [1:0]       fmt,
  input  logic             wr_en,
  input  logic [HW-1:0]    wr_data,
  input  logic             underrun_clr,
  output logic             tx_empty,
  output logic             ch_right,
  output logic             underrun,
  output logic             busy,
  output logic             sck,
  output logic             ws,
  output logic             sd
);
  localparam int SLOT_W = 2 * HW;

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic [DIV_W-1:0]  div_q;
  fmt_e              fmt_q;
  logic              busy_w;
  logic              fall_w;
  logic              load_w;
  logic              full_w;
  logic              right_w;
  logic [SLOT_W-1:0] word_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      div_q <= DIV_W'(1);
      fmt_q <= FMT_16_16;
    end else if (!busy_w) begin
      div_q <= half_div;
      fmt_q <= fmt_e'(fmt);
    end
  end

  i2s_sck_gen #(.DIV_W(DIV_W)) u_sck (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .run      (busy_w),
    .half_div (div_q),
    .sck      (sck),
    .fall     (fall_w)
  );

  i2s_sample_stager #(.HW(HW)) u_stage (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .fmt          (fmt_q),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .load         (load_w),
    .underrun_clr (underrun_clr),
    .word         (word_w),
    .full         (full_w),
    .next_right   (right_w),
    .underrun     (underrun)
  );

  i2s_serializer #(.SLOT_W(SLOT_W)) u_ser (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .enable     (enable),
    .fmt        (fmt_q),
    .fall       (fall_w),
    .word       (word_w),
    .next_right (right_w),
    .busy       (busy_w),
    .load       (load_w),
    .ws         (ws),
    .sd         (sd)
  );

  assign busy     = busy_w;
  assign tx_empty = ~full_w;
  assign ch_right = right_w;
endmodule

// File: rtl/i2s_tx_master_chk.sv
module i2s_tx_master_chk #(
  parameter int HW    = 16,
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [DIV_W-1:0] half_div,
  input logic [1:0]       fmt,
  input logic             wr_en,
  input logic [HW-1:0]    wr_data,
  input logic             underrun_clr,
  input logic             tx_empty,
  input logic             ch_right,
  input logic             underrun,
  input logic             busy,
  input logic             sck,
  input logic             ws,
  input logic             sd
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sck && !ws && !sd)); // R6

  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> ($stable(sd) && $stable(ws))); // R6

  AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ws != $past(ws)) |-> $fell(sck)); // R5

  AST_SIDE_AT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_right != $past(ch_right)) |-> $fell(sck)); // R4

  AST_EMPTY_AT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty) |-> $fell(sck)); // R8

  AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !underrun_clr) |=> underrun); // R9

  AST_UNDERRUN_AT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $fell(sck)); // R9
endmodule

bind i2s_tx_master i2s_tx_master_chk #(.HW(HW), .DIV_W(DIV_W)) u_chk (.*);

// File: tb/i2s_tx_master_tb.sv
module i2s_tx_master_tb;
  localparam int HW    = 16;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n;
  logic             enable;
  logic [DIV_W-1:0] half_div;
  logic [1:0]       fmt;
  logic             wr_en;
  logic [HW-1:0]    wr_data;
  logic             underrun_clr;
  logic             tx_empty, ch_right, underrun, busy, sck, ws, sd;

  int checks = 0;
  int errors = 0;

  i2s_tx_master #(.HW(HW), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .half_div(half_div), .fmt(fmt),
    .wr_en(wr_en), .wr_data(wr_data), .underrun_clr(underrun_clr),
    .tx_empty(tx_empty), .ch_right(ch_right), .underrun(underrun), .busy(busy),
    .sck(sck), .ws(ws), .sd(sd)
  );

  logic        cap_on = 1'b0;
  int          nrise  = 0;
  logic        cap_ws [0:1023];
  logic        cap_sd [0:1023];
  time         cap_t  [0:1023];
  logic [31:0] exp_w  [0:15];

  always @(posedge sck) begin
    if (cap_on && nrise < 1024) begin
      cap_ws[nrise] = ws;
      cap_sd[nrise] = sd;
      cap_t[nrise]  = $time;
      nrise = nrise + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int f, input logic [15:0] hi, input logic [15:0] lo);
    case (f)
      0, 1:    return {hi, 16'h0000};
      2:       return {hi, lo[15:8], 8'h00};
      default: return {hi, lo};
    endcase
  endfunction

  task automatic put(input logic [15:0] d);
    @(negedge clk);
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic write_sample(input int f, input logic [15:0] hi, input logic [15:0] lo);
    put(hi);
    if (f >= 2) put(lo);
  endtask

  task automatic wait_empty();
    for (int n = 0; n < 5000 && !tx_empty; n++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 8000 && busy; n++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic set_cfg(input int f, input int hd);
    @(negedge clk);
    fmt      = 2'(f);
    half_div = DIV_W'(hd);
    repeat (3) @(negedge clk);
  endtask

  task automatic verify(input int f, input int hd, input int nslot, input string rq);
    int  slot;
    int  hde;
    bit  pok;
    slot = (f == 0) ? 16 : 32;
    hde  = (hd == 0) ? 1 : hd;
    chk(nrise == 1 + nslot * slot, "R10", 32'(nrise), 32'(1 + nslot * slot));
    chk(cap_ws[0] == 1'b0 && cap_sd[0] == 1'b0, "R5", {30'd0, cap_ws[0], cap_sd[0]}, 32'd0);
    for (int s = 0; s < nslot; s++) begin
      logic [31:0] got;
      bit          wok;
      got = '0;
      wok = 1'b1;
      for (int b = 0; b < slot; b++) begin
        logic ews;
        got[31-b] = cap_sd[1 + s * slot + b];
        ews = (b == slot - 1) ? ~s[0] : s[0];
        if (cap_ws[1 + s * slot + b] != ews) wok = 1'b0;
      end
      chk(got == exp_w[s], rq, got, exp_w[s]);
      chk(wok, "R5", {31'd0, wok}, 32'd1);
    end
    pok = 1'b1;
    for (int i = 1; i < nrise; i++)
      if ((cap_t[i] - cap_t[i-1]) != time'(20 * hde)) pok = 1'b0;
    chk(pok, "R7", {31'd0, pok}, 32'd1);
    chk(!busy && !sck && !ws && !sd, "R10", {28'd0, busy, sck, ws, sd}, 32'd0);
    chk(tx_empty && !ch_right, "R4", {30'd0, tx_empty, ch_right}, 32'd2);
  endtask

  task automatic run_stream(input int f, input int hd, input int nfr);
    int          nslot;
    logic [15:0] hi, lo;
    string       rq;
    nslot = 2 * nfr;
    rq = (f == 0) ? "R1" : (f == 1) ? "R2" : "R3";
    set_cfg(f, hd);
    nrise  = 0;
    cap_on = 1'b1;
    chk(ch_right == 1'b0, "R4", {31'd0, ch_right}, 32'd0);
    hi = 16'h8001 ^ 16'(f * 16'h0F00);
    lo = 16'h00C3 ^ 16'(hd);
    exp_w[0] = exp_word(f, hi, lo);
    write_sample(f, hi, lo);
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    half_div = DIV_W'(hd + 4);
    for (int k = 1; k < nslot; k++) begin
      wait_empty();
      chk(ch_right == k[0], "R4", {31'd0, ch_right}, {31'd0, k[0]});
      hi = 16'h8001 ^ 16'(k * 16'h1D35) ^ 16'(f * 16'h0F00);
      lo = 16'h00C3 ^ 16'(k * 16'h2B61) ^ 16'(hd);
      exp_w[k] = exp_word(f, hi, lo);
      write_sample(f, hi, lo);
    end
    enable = 1'b0;
    wait_idle();
    cap_on   = 1'b0;
    half_div = DIV_W'(hd);
    verify(f, hd, nslot, rq);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    enable = 1'b0; half_div = '0; fmt = 2'd0; wr_en = 1'b0; wr_data = '0; underrun_clr = 1'b0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !sck && !ws && !sd, "R6", {28'd0, busy, sck, ws, sd}, 32'd0);
    chk(tx_empty && !ch_right && !underrun, "R8", {29'd0, tx_empty, ch_right, underrun}, 32'd4);

    for (int f = 0; f < 4; f++)
      for (int h = 0; h < 3; h++)
        run_stream(f, (h == 0) ? 0 : h + 1, 2);

    // R8: a write while the buffer is full is discarded
    set_cfg(0, 1);
    nrise  = 0;
    cap_on = 1'b1;
    put(16'h1234);
    chk(!tx_empty, "R8", {31'd0, tx_empty}, 32'd0);
    put(16'h5555);
    exp_w[0] = 32'h1234_0000;
    enable = 1'b1;
    wait_empty();
    chk(ch_right, "R4", {31'd0, ch_right}, 32'd1);
    put(16'hBEEF);
    exp_w[1] = 32'hBEEF_0000;
    enable = 1'b0;
    wait_idle();
    cap_on = 1'b0;
    verify(0, 1, 2, "R8");

    // R9: underrun with a half-written sample
    set_cfg(3, 1);
    nrise  = 0;
    cap_on = 1'b1;
    put(16'hDEAD);
    enable = 1'b1;
    for (int n = 0; n < 2000 && !ch_right; n++) @(negedge clk);
    chk(underrun, "R9", {31'd0, underrun}, 32'd1);
    chk(tx_empty, "R9", {31'd0, tx_empty}, 32'd1);
    write_sample(3, 16'h1357, 16'h9BDF);
    exp_w[0] = 32'h0000_0000;
    exp_w[1] = 32'h1357_9BDF;
    enable = 1'b0;
    wait_idle();
    cap_on = 1'b0;
    verify(3, 1, 2, "R9");
    chk(underrun, "R9", {31'd0, underrun}, 32'd1);
    @(negedge clk);
    underrun_clr = 1'b1;
    @(negedge clk);
    underrun_clr = 1'b0;
    @(negedge clk);
    chk(!underrun, "R9", {31'd0, underrun}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule